// File: doc/BRIEF.md
# Columnar Scan Predicate Engine

This block filters a column of unsigned integers that arrive densely bit-packed in 64-bit words. Software first sets the value width, a predicate mode, two compare bounds, an element count and a 256-entry membership bitmap through a small register port. It then writes the start register. The engine takes input words over a valid/ready stream and extracts one value per cycle, including values that straddle two input words. It tests each value against the chosen predicate and packs one result bit per value into 64-bit result words, which leave over a second valid/ready stream.

Only the bitmap of matching rows leaves the engine, so a consumer can pick rows without reading the column back. Unpacking, testing and packing happen in the same cycle on the same element. A stalled output word freezes the whole path, so no element is lost or repeated. A one-cycle done pulse follows acceptance of the final result word.

Top module: `scan_predicate_engine`

## Requirements
- R1: After reset, in_ready, out_valid and done are all low.
- R2: With width W (1 to 32), element i occupies stream bits i*W to i*W+W-1. Bit k of the stream is bit k%64 of input word k/64, so a value may straddle two input words.
- R3: Mode 0 (equality) yields 1 for an element exactly when it equals the low bound.
- R4: Mode 1 (range) yields 1 when low <= v <= high, using unsigned comparison. Both bounds are inclusive.
- R5: Mode 2 (member) yields the bitmap entry indexed by v[7:0]. Register 8+k holds entries 32k to 32k+31, and data bit j is entry 32k+j.
- R6: Mode 3 (non-member) yields the complement of the mode 2 result.
- R7: Result bit i appears at bit i%64 of result word i/64. Exactly ceil(count/64) words are emitted, and the unused tail of the last word is zero.
- R8: A task consumes exactly ceil(count*W/64) input words. in_ready stays low outside a task and once they are consumed.
- R9: While out_valid is high and out_ready low, out_data holds steady and out_valid stays high. Under any pattern of stalls, every result is delivered once.
- R10: done is high for exactly one cycle, the cycle after the final result word is accepted. With count 0, done is high in the cycle after the start write, and no word moves on either stream.
- R11: Configuration writes, including start, are ignored while a task is running. Register map: 0 width[5:0], 1 mode[1:0], 2 low bound, 3 high bound, 4 count, 5 start, 8 to 15 bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Packed column word offered |
| in_ready | output | 1 | Engine accepts the offered word |
| in_data | input | 64 | Packed column word |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Consumer accepts the result word |
| out_data | output | 64 | Packed result bits |
| done | output | 1 | One-cycle task completion pulse |

## Verification
The hardest case to reach from the ports has three parts at once. A result word has just filled and is stalled. The input side is holding part of a value that straddles two words. The input stream has gaps, so the next word is late. Only widths that do not divide 64 produce straddling values, and only random output-ready gaps land a stall on a full word. The stimulus therefore mixes many random widths and counts with both sparse and dense valid and ready patterns. Directed cases cover a single element, exact word fills, a one-bit overflow into a second result word, inclusive range edges, an empty task and a configuration write during a run.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      PM_EQ     = 2'd0,
      PM_RANGE  = 2'd1,
      PM_MEMBER = 2'd2,
      PM_NOTMEM = 2'd3
   } pmode_e;

   localparam int ADDR_W   = 4;
   localparam logic [ADDR_W-1:0] A_WIDTH = 4'd0;
   localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
   localparam logic [ADDR_W-1:0] A_LO    = 4'd2;
   localparam logic [ADDR_W-1:0] A_HI    = 4'd3;
   localparam logic [ADDR_W-1:0] A_COUNT = 4'd4;
   localparam logic [ADDR_W-1:0] A_START = 4'd5;
   localparam int TBL_BASE = 8;
endpackage

// File: rtl/scan_unpack.sv
module scan_unpack #(
   parameter int WORD_W    = 64,
   parameter int VAL_W_MAX = 32,
   parameter int CNT_W     = 16,
   localparam int WID_W    = $clog2(VAL_W_MAX) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [WID_W-1:0]     cfg_width,
   input  logic [CNT_W-1:0]     cfg_count,
   input  logic                 in_valid,
   input  logic [WORD_W-1:0]    in_data,
   output logic                 in_ready,
   input  logic                 take,
   output logic                 val_valid,
   output logic [VAL_W_MAX-1:0] val,
   output logic                 val_last
);
   localparam int BUF_W  = 2 * WORD_W;
   localparam int FILL_W = $clog2(BUF_W) + 1;
   localparam int IDX_W  = $clog2(WORD_W);
   localparam int TOT_W  = CNT_W + WID_W;
   localparam logic [WID_W-1:0] VMAX = WID_W'(VAL_W_MAX);

   logic [BUF_W-1:0]  buf_q, buf_sh, buf_n;
   logic [FILL_W-1:0] fill_q, fill_sh, fill_n, shamt;
   logic [CNT_W-1:0]  left_q;
   logic [TOT_W-1:0]  words_q;
   logic [TOT_W:0]    bits_needed;
   logic [VAL_W_MAX-1:0] mask;
   logic              hs;

   assign in_ready  = (words_q != '0) && (fill_q <= FILL_W'(WORD_W));
   assign hs        = in_valid && in_ready;
   assign val_valid = (left_q != '0) && (fill_q >= FILL_W'(cfg_width));
   assign mask      = {VAL_W_MAX{1'b1}} >> (VMAX - cfg_width);
   assign val       = buf_q[VAL_W_MAX-1:0] & mask;
   assign val_last  = (left_q == CNT_W'(1));

   assign bits_needed = (TOT_W+1)'(cfg_count) * (TOT_W+1)'(cfg_width)
                      + (TOT_W+1)'(WORD_W - 1);

   always_comb begin
      shamt   = take ? FILL_W'(cfg_width) : '0;
      buf_sh  = buf_q >> shamt;
      fill_sh = fill_q - shamt;
      buf_n   = buf_sh;
      fill_n  = fill_sh;
      if (hs) begin
         buf_n  = buf_sh | ({{WORD_W{1'b0}}, in_data} << fill_sh);
         fill_n = fill_sh + FILL_W'(WORD_W);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q   <= '0;
         fill_q  <= '0;
         left_q  <= '0;
         words_q <= '0;
      end else if (load) begin
         buf_q   <= '0;
         fill_q  <= '0;
         left_q  <= cfg_count;
         words_q <= TOT_W'(bits_needed >> IDX_W);
      end else begin
         buf_q  <= buf_n;
         fill_q <= fill_n;
         if (take) left_q  <= left_q - CNT_W'(1);
         if (hs)   words_q <= words_q - TOT_W'(1);
      end
   end
endmodule

// File: rtl/scan_pred.sv
module scan_pred
   import scan_pkg::*;
#(
   parameter int VAL_W_MAX = 32,
   parameter int TBL_AW    = 8
) (
   input  pmode_e                   mode,
   input  logic [VAL_W_MAX-1:0]     lo,
   input  logic [VAL_W_MAX-1:0]     hi,
   input  logic [(1<<TBL_AW)-1:0]   tbl,
   input  logic [VAL_W_MAX-1:0]     v,
   output logic                     hit
);
   logic member;
   assign member = tbl[v[TBL_AW-1:0]];

   always_comb begin
      unique case (mode)
         PM_EQ:     hit = (v == lo);
         PM_RANGE:  hit = (v >= lo) && (v <= hi);
         PM_MEMBER: hit = member;
         PM_NOTMEM: hit = !member;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/scan_pack.sv
module scan_pack #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              bit_valid,
   input  logic              bit_in,
   input  logic              bit_last,
   output logic              bit_take,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              fin
);
   localparam int IDX_W = $clog2(WORD_W);

   logic [WORD_W-1:0] acc_q, acc_n;
   logic [IDX_W-1:0]  idx_q;
   logic              last_q;

   assign bit_take = bit_valid && !out_valid;
   assign acc_n    = acc_q | (WORD_W'(bit_in) << idx_q);
   assign fin      = out_valid && out_ready && last_q;

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         acc_q     <= '0;
         idx_q     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         last_q    <= 1'b0;
      end else begin
         if (out_valid && out_ready) out_valid <= 1'b0;
         if (bit_take) begin
            if (bit_last || idx_q == IDX_W'(WORD_W - 1)) begin
               out_data  <= acc_n;
               out_valid <= 1'b1;
               last_q    <= bit_last;
               acc_q     <= '0;
               idx_q     <= '0;
            end else begin
               acc_q <= acc_n;
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/scan_predicate_engine.sv
module scan_predicate_engine
   import scan_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int VAL_W_MAX = 32,
   parameter int CNT_W     = 16,
   parameter int TBL_AW    = 8,
   parameter int CFG_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              done
);
   localparam int WID_W     = $clog2(VAL_W_MAX) + 1;
   localparam int TBL_N     = 1 << TBL_AW;
   localparam int TBL_WORDS = TBL_N / CFG_W;

   if (VAL_W_MAX > WORD_W || VAL_W_MAX > CFG_W) begin : g_bad_val
      $error("value width exceeds word or config width");
   end
   if (TBL_AW > VAL_W_MAX || TBL_N % CFG_W != 0) begin : g_bad_tbl
      $error("bitmap size must be indexable and a multiple of config width");
   end
   if (TBL_BASE + TBL_WORDS > (1 << ADDR_W) || CNT_W > CFG_W) begin : g_bad_map
      $error("register map does not fit");
   end

   logic [WID_W-1:0]     width_q;
   pmode_e               mode_q;
   logic [VAL_W_MAX-1:0] lo_q, hi_q;
   logic [CNT_W-1:0]     count_q;
   logic [TBL_N-1:0]     tbl_q;
   logic                 busy_q;
   logic                 wr_ok, start;

   logic                 val_valid, val_last, take, hit, fin;
   logic [VAL_W_MAX-1:0] val;

   assign wr_ok = cfg_we && !busy_q;
   assign start = wr_ok && (cfg_addr == A_START);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         width_q <= WID_W'(1);
         mode_q  <= PM_EQ;
         lo_q    <= '0;
         hi_q    <= '0;
         count_q <= '0;
         tbl_q   <= '0;
         busy_q  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= fin || (start && count_q == '0);
         if (fin) busy_q <= 1'b0;
         if (start && count_q != '0) busy_q <= 1'b1;
         if (wr_ok) begin
            unique case (cfg_addr)
               A_WIDTH: width_q <= cfg_wdata[WID_W-1:0];
               A_MODE:  mode_q  <= pmode_e'(cfg_wdata[1:0]);
               A_LO:    lo_q    <= cfg_wdata[VAL_W_MAX-1:0];
               A_HI:    hi_q    <= cfg_wdata[VAL_W_MAX-1:0];
               A_COUNT: count_q <= cfg_wdata[CNT_W-1:0];
               default: ;
            endcase
            for (int k = 0; k < TBL_WORDS; k++) begin
               if (cfg_addr == ADDR_W'(TBL_BASE + k))
                  tbl_q[k*CFG_W +: CFG_W] <= cfg_wdata;
            end
         end
      end
   end

   scan_unpack #(.WORD_W(WORD_W), .VAL_W_MAX(VAL_W_MAX), .CNT_W(CNT_W)) u_unpack (
      .clk(clk), .rst_n(rst_n), .load(start),
      .cfg_width(width_q), .cfg_count(count_q),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .take(take), .val_valid(val_valid), .val(val), .val_last(val_last)
   );

   scan_pred #(.VAL_W_MAX(VAL_W_MAX), .TBL_AW(TBL_AW)) u_pred (
      .mode(mode_q), .lo(lo_q), .hi(hi_q), .tbl(tbl_q), .v(val), .hit(hit)
   );

   scan_pack #(.WORD_W(WORD_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .load(start),
      .bit_valid(val_valid), .bit_in(hit), .bit_last(val_last), .bit_take(take),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .fin(fin)
   );
endmodule

// File: rtl/scan_engine_chk.sv
module scan_engine_chk #(
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic              done
);
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_ready && !out_valid); // R8
endmodule

bind scan_predicate_engine scan_engine_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_q), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/tb_scan_predicate_engine.sv
module tb_scan_predicate_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [63:0] out_data;
   logic        done;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0]  elem [0:511];
   logic [63:0]  in_words [0:511];
   logic [63:0]  got [0:63];
   logic [255:0] tbl;

   always #4 clk = ~clk;

   scan_predicate_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit pred(input int mode, input logic [31:0] v, input logic [31:0] lo, input logic [31:0] hi);
      case (mode)
         0: return v == lo;
         1: return (v >= lo) && (v <= hi);
         2: return tbl[v[7:0]];
         default: return !tbl[v[7:0]];
      endcase
   endfunction

   function automatic logic [31:0] wmask(input int width);
      logic [63:0] m = (64'd1 << width) - 64'd1;
      return m[31:0];
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic run(input int width, input int mode, input logic [31:0] lo, input logic [31:0] hi,
                      input int count, input int vgap, input int rgap, input bit mid_write);
      int n_in, idx, n_got, dones, post, holdbad, extra, nwords;
      bit hsi, hso, seen, held;
      logic [63:0] hold_d, expw;
      string tag;
      tag = (mode == 0) ? "R3" : (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
      n_in = (count * width + 63) / 64;
      for (int w = 0; w < 512; w++) in_words[w] = '0;
      for (int i = 0; i < count; i++)
         for (int b = 0; b < width; b++)
            in_words[(i*width+b)/64][(i*width+b)%64] = elem[i][b];
      wr(4'd0, width); wr(4'd1, mode); wr(4'd2, lo); wr(4'd3, hi); wr(4'd4, count);
      for (int k = 0; k < 8; k++) wr(4'(8 + k), tbl[32*k +: 32]);
      wr(4'd5, 32'd0);
      idx = 0; n_got = 0; dones = 0; post = 0; holdbad = 0; extra = 0;
      seen = 0; held = 0; hold_d = '0;
      for (int cyc = 0; cyc < 20000 && post < 4; cyc++) begin
         @(negedge clk);
         hsi = in_valid && in_ready;
         hso = out_valid && out_ready;
         if (held && !(out_valid && out_data == hold_d)) holdbad++;
         held = out_valid && !out_ready;
         hold_d = out_data;
         if (hso && n_got < 64) begin got[n_got] = out_data; n_got++; end
         if (idx >= n_in && in_ready) extra++;
         if (done) begin dones++; seen = 1; end
         if (seen) post++;
         @(posedge clk); #1;
         if (hsi) idx++;
         in_valid  = (idx < n_in) && (($urandom % 100) >= vgap);
         in_data   = in_words[idx];
         out_ready = ($urandom % 100) >= rgap;
         cfg_we    = mid_write && (cyc == 2);
         cfg_addr  = 4'd1;
         cfg_wdata = 32'(mode ^ 1);
      end
      cfg_we = 1'b0; in_valid = 1'b0;
      chk(seen, "R10 done seen before watchdog", 64'(dones), 64'd1);
      chk(dones == 1, "R10 single done pulse", 64'(dones), 64'd1);
      chk(idx == n_in && extra == 0, "R8 input word count", 64'(idx * 1000 + extra), 64'(n_in * 1000));
      chk(holdbad == 0, "R9 stalled word held", 64'(holdbad), 64'd0);
      nwords = (count + 63) / 64;
      chk(n_got == nwords, "R7 result word count", 64'(n_got), 64'(nwords));
      for (int w = 0; w < nwords && w < n_got; w++) begin
         expw = '0;
         for (int j = 0; j < 64; j++)
            if (w*64 + j < count) expw[j] = pred(mode, elem[w*64+j], lo, hi);
         chk(got[w] == expw, $sformatf("%s R2 R7 R11 word %0d w=%0d", tag, w, width), got[w], expw);
      end
   endtask

   task automatic fill_elems(input int width, input int count);
      for (int i = 0; i < count; i++) elem[i] = $urandom & wmask(width);
   endtask

   initial begin
      int width, mode, count;
      logic [31:0] lo, hi, a, b;
      void'($urandom(32'd20140));
      tbl = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!in_ready && !out_valid && !done, "R1 reset state",
          {61'd0, in_ready, out_valid, done}, 64'd0);

      // directed corners
      fill_elems(1, 1);
      run(1, 3, 0, 0, 1, 0, 0, 0);
      fill_elems(32, 64);
      elem[5] = 32'hFFFF_FFFF;
      run(32, 0, 32'hFFFF_FFFF, 0, 64, 10, 10, 0);
      fill_elems(7, 65);
      run(7, 2, 0, 0, 65, 30, 60, 0);
      for (int i = 0; i < 40; i++) elem[i] = 32'(i);
      run(13, 1, 32'd10, 32'd20, 40, 0, 80, 0);
      run(13, 1, 32'd17, 32'd17, 40, 50, 0, 0);
      fill_elems(9, 100);
      elem[3] = 9'd321;
      run(9, 0, 32'd321, 0, 100, 20, 20, 1);

      // empty task
      wr(4'd4, 32'd0);
      wr(4'd5, 32'd0);
      chk(done && !out_valid && !in_ready, "R10 empty task done", {62'd0, done, out_valid}, 64'd2);
      @(posedge clk); #1;
      chk(!done, "R10 empty task pulse width", 64'(done), 64'd0);

      // random tasks
      for (int t = 0; t < 30; t++) begin
         width = 1 + ($urandom % 32);
         mode  = $urandom % 4;
         count = 1 + ($urandom % 300);
         fill_elems(width, count);
         a = $urandom & wmask(width);
         b = $urandom & wmask(width);
         lo = (a < b) ? a : b;
         hi = (a < b) ? b : a;
         if (mode == 0) lo = elem[$urandom % count];
         tbl = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
         run(width, mode, lo, hi, count, $urandom % 60, $urandom % 60, t % 5 == 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule